// File: doc/BRIEF.md
# Snapshot Time-of-Day Calendar Counter

This block keeps time of day and calendar date as a chain of binary counters: hundredths of a second, seconds, minutes, hours, day of month, month, two-digit year and day of week. The chain advances once for each single-cycle pulse on a 100 Hz tick input. A small register port lets software load any counter and read all of them back.

Reading eight counters one at a time over a narrow bus can tear. For example, the seconds could roll over between two reads. To prevent this, a read of the hundredths register returns the live hundredths value and, on the same clock edge, copies the other seven counters into holding registers. Reads of those seven addresses return the held copies, and the copies stay fixed until the next hundredths read. Software therefore reads hundredths first and then the rest, and gets one consistent time.

Each counter also drives a one-cycle advance pulse. Neighbouring logic can use these pulses as periodic event sources.

Top module: `rtc_snapshot_core`

## Requirements
- R1: After reset, every counter is 0 except day of month and month, which are 1. `rdata`, all holding registers and all `inc_pulse` bits are 0.
- R2: Each tick advances hundredths by one. Hundredths wraps from 99 to 0 and carries into seconds. Seconds and minutes wrap from 59 to 0 and hours from 23 to 0, each carrying into the next field.
- R3: When hours wraps, day of week and day of month advance together. Day of week wraps from 6 to 0.
- R4: Day of month wraps to 1 when it is at or above the length of the current month, and then month advances. Months 4, 6, 9 and 11 have 30 days. Month 2 has 29 days when the year is divisible by 4 and 28 otherwise. All other months have 31 days. Month wraps from 12 to 1 and advances the year. Year wraps from 99 to 0.
- R5: Address map (3-bit `addr`): 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day of month, 5 month, 6 year, 7 day of week. All values are plain binary.
- R6: A read (`rd_en` high for one cycle) places its result on `rdata` in the following cycle. `rdata` holds that value until the next read.
- R7: A read of address 0 returns the live hundredths count. The same edge copies the seven other counters into holding registers.
- R8: A read of addresses 1 to 7 returns the holding register for that address. Ticks do not change these registers, only the next address-0 read does.
- R9: A write (`wr_en`) loads `wdata` into the live counter at `addr`, visible in the next cycle. It leaves the holding registers unchanged. A tick that arrives in the same cycle as a write is dropped, and no counter advances.
- R10: `inc_pulse[a]` is high for exactly the one cycle after a tick advances the counter at address `a`, wraps included. Writes raise no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Single-cycle 100 Hz advance pulse |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| inc_pulse | output | 8 | Per-counter advance pulses, bit index equals address |

## Verification
The range properties take for granted that software writes only values inside each field's legal range: 0 to 99 for hundredths and year, 0 to 59 for seconds and minutes, 0 to 23 for hours, 1 to 31 for day of month, 1 to 12 for month, and 0 to 6 for day of week.

The random stimulus draws every write value from that field's legal range. It then mixes writes with ticks and with reads of both the trigger address and the held addresses.

A day of month that is legal on its own but too large for a later month, such as 31 left in place after month is set to 4, is allowed. The at-or-above wrap rule of R4 covers that case.

// File: rtl/rtc_snap_pkg.sv
package rtc_snap_pkg;
  localparam int NUM_FIELDS = 8;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = $clog2(NUM_FIELDS);

  // Field positions double as register addresses.
  localparam int F_HUND = 0;
  localparam int F_SEC  = 1;
  localparam int F_MIN  = 2;
  localparam int F_HOUR = 3;
  localparam int F_DATE = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;
  localparam int F_DOW  = 7;

  function automatic int field_lo(int f);
    return (f == F_DATE || f == F_MON) ? 1 : 0;
  endfunction

  // Highest legal value of each field; day of month is replaced by month length.
  function automatic int field_top(int f);
    case (f)
      F_HUND:  return 99;
      F_SEC:   return 59;
      F_MIN:   return 59;
      F_HOUR:  return 23;
      F_DATE:  return 31;
      F_MON:   return 12;
      F_YEAR:  return 99;
      default: return 6;
    endcase
  endfunction
endpackage

// File: rtl/rtc_field_ctr.sv
module rtc_field_ctr #(
  parameter int W  = 8,
  parameter int LO = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] top,
  output logic [W-1:0] val,
  output logic         at_top,
  output logic         stepped
);
  localparam logic [W-1:0] LO_V = W'(LO);

  logic [W-1:0] val_d, val_q;
  logic         step_d, step_q;

  // At-or-above compare so an out-of-month day still wraps.
  assign at_top = (val_q >= top);

  always_comb begin
    val_d  = val_q;
    step_d = 1'b0;
    if (ld) begin
      val_d = ld_val;
    end else if (adv) begin
      step_d = 1'b1;
      val_d  = at_top ? LO_V : val_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= LO_V;
      step_q <= 1'b0;
    end else begin
      step_q <= step_d;
      if (ld || adv) val_q <= val_d;
    end
  end

  assign val     = val_q;
  assign stepped = step_q;
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len #(
  parameter int W = 8
) (
  input  logic [W-1:0] month,
  input  logic [W-1:0] year,
  output logic [W-1:0] last_day
);
  logic leap;

  assign leap = ((year & W'(3)) == '0);

  always_comb begin
    case (month)
      W'(2):                      last_day = leap ? W'(29) : W'(28);
      W'(4), W'(6), W'(9), W'(11): last_day = W'(30);
      default:                    last_day = W'(31);
    endcase
  end
endmodule

// File: rtl/rtc_snap_hold.sv
module rtc_snap_hold
  import rtc_snap_pkg::*;
#(
  parameter int NF = NUM_FIELDS,
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  input  logic [NF*DW-1:0] live,
  output logic [DW-1:0]    rdata
);
  logic [NF-1:0][DW-1:0] hold_d, hold_q;
  logic [DW-1:0]         rdata_d, rdata_q;
  logic                  trig;

  assign trig = rd_en && (rd_addr == AW'(F_HUND));

  always_comb begin
    hold_d  = hold_q;
    rdata_d = rdata_q;
    if (trig) begin
      rdata_d = live[F_HUND*DW +: DW];
      for (int f = 0; f < NF; f++) begin
        if (f != F_HUND) hold_d[f] = live[f*DW +: DW];
      end
    end else if (rd_en) begin
      rdata_d = hold_q[rd_addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (trig)  hold_q  <= hold_d;
      if (rd_en) rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/rtc_snapshot_core.sv
module rtc_snapshot_core
  import rtc_snap_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NF = NUM_FIELDS,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [NF-1:0] inc_pulse
);
  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [DW-1:0]    cnt     [NF];
  logic [DW-1:0]    top_val [NF];
  logic [NF-1:0]    adv, at_top, ld, stepped;
  logic [NF*DW-1:0] cnt_flat;
  logic [DW-1:0]    month_last;
  logic             day_roll;

  rtc_month_len #(.W(DW)) u_mlen (
    .month    (cnt[F_MON]),
    .year     (cnt[F_YEAR]),
    .last_day (month_last)
  );

  // Carry chain; a write cycle drops the tick.
  always_comb begin
    adv         = '0;
    adv[F_HUND] = tick & ~wr_en;
    adv[F_SEC]  = adv[F_HUND] & at_top[F_HUND];
    adv[F_MIN]  = adv[F_SEC]  & at_top[F_SEC];
    adv[F_HOUR] = adv[F_MIN]  & at_top[F_MIN];
    day_roll    = adv[F_HOUR] & at_top[F_HOUR];
    adv[F_DATE] = day_roll;
    adv[F_DOW]  = day_roll;
    adv[F_MON]  = adv[F_DATE] & at_top[F_DATE];
    adv[F_YEAR] = adv[F_MON]  & at_top[F_MON];
  end

  for (genvar f = 0; f < NF; f++) begin : g_field
    if (f == F_DATE) begin : g_var_top
      assign top_val[f] = month_last;
    end else begin : g_fix_top
      assign top_val[f] = DW'(field_top(f));
    end

    assign ld[f] = wr_en && (addr == AW'(f));

    rtc_field_ctr #(.W(DW), .LO(field_lo(f))) u_ctr (
      .clk     (clk),
      .rst_n   (rst_sync_q),
      .adv     (adv[f]),
      .ld      (ld[f]),
      .ld_val  (wdata),
      .top     (top_val[f]),
      .val     (cnt[f]),
      .at_top  (at_top[f]),
      .stepped (stepped[f])
    );

    assign cnt_flat[f*DW +: DW] = cnt[f];
  end

  rtc_snap_hold #(.NF(NF), .DW(DW), .AW(AW)) u_hold (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .rd_en   (rd_en),
    .rd_addr (addr),
    .live    (cnt_flat),
    .rdata   (rdata)
  );

  assign inc_pulse = stepped;
endmodule

// File: rtl/rtc_snapshot_core_chk.sv
module rtc_snapshot_core_chk
  import rtc_snap_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NF = NUM_FIELDS,
  parameter int AW = ADDR_W
) (
  input logic             clk,
  input logic             rst_ni,
  input logic             tick,
  input logic             wr_en,
  input logic             rd_en,
  input logic [AW-1:0]    addr,
  input logic [DW-1:0]    wdata,
  input logic [DW-1:0]    rdata,
  input logic [NF-1:0]    inc_pulse,
  input logic [NF*DW-1:0] cnt_flat
);
  logic [DW-1:0] c_hund, c_date, c_dow;
  assign c_hund = cnt_flat[F_HUND*DW +: DW];
  assign c_date = cnt_flat[F_DATE*DW +: DW];
  assign c_dow  = cnt_flat[F_DOW*DW  +: DW];

  p_hund_wrap_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (tick && !wr_en && c_hund == DW'(99)) |=> (c_hund == '0 && inc_pulse[F_SEC]));

  p_dow_range_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    c_dow <= DW'(6));

  p_day_pair_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    inc_pulse[F_DATE] == inc_pulse[F_DOW]);

  p_date_range_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (c_date >= DW'(1)) && (c_date <= DW'(31)));

  p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    !$past(rd_en) |-> $stable(rdata));

  p_write_load_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_en |=> (cnt_flat[$past(addr)*DW +: DW] == $past(wdata)));

  p_write_quiet_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_en |=> (inc_pulse == '0));

  p_pulse_root_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (|inc_pulse) |-> (inc_pulse[F_HUND] && $past(tick)));
endmodule

bind rtc_snapshot_core rtc_snapshot_core_chk #(.DW(DW), .NF(NF), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_ni    (rst_sync_q),
  .tick      (tick),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .addr      (addr),
  .wdata     (wdata),
  .rdata     (rdata),
  .inc_pulse (inc_pulse),
  .cnt_flat  (cnt_flat)
);

// File: tb/tb_rtc_snapshot_core.sv
module tb_rtc_snapshot_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] inc_pulse;

  int m[8];
  int snap[8];
  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rtc_snapshot_core dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .inc_pulse(inc_pulse)
  );

  function automatic int mlen(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic int lo_of(int i);
    return (i == 4 || i == 5) ? 1 : 0;
  endfunction

  function automatic int top_of(int i);
    case (i)
      0: return 99; 1: return 59; 2: return 59; 3: return 23;
      4: return 31; 5: return 12; 6: return 99; default: return 6;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected model step per R2, R3, R4; returns the advanced-field mask (R10).
  function automatic int model_tick();
    bit t[8];
    bit a[8];
    int mask = 0;
    for (int i = 0; i < 8; i++)
      t[i] = (m[i] >= ((i == 4) ? mlen(m[5], m[6]) : top_of(i)));
    a[0] = 1'b1;
    a[1] = a[0] & t[0];
    a[2] = a[1] & t[1];
    a[3] = a[2] & t[2];
    a[4] = a[3] & t[3];
    a[7] = a[4];
    a[5] = a[4] & t[4];
    a[6] = a[5] & t[5];
    for (int i = 0; i < 8; i++) begin
      if (a[i]) begin
        m[i] = t[i] ? lo_of(i) : m[i] + 1;
        mask |= (1 << i);
      end
    end
    return mask;
  endfunction

  task automatic do_tick();
    int expm;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    expm = model_tick();
    chk("R10 advance pulses", int'(inc_pulse), expm);
  endtask

  task automatic do_write(int a, int v);
    wr_en = 1'b1; addr = 3'(a); wdata = 8'(v);
    @(negedge clk);
    wr_en = 1'b0;
    m[a] = v;
    chk("R10 no pulse on write", int'(inc_pulse), 0);
  endtask

  task automatic do_read(int a, string tag);
    int exp;
    rd_en = 1'b1; addr = 3'(a);
    @(negedge clk);
    rd_en = 1'b0;
    if (a == 0) begin
      exp = m[0];
      for (int i = 1; i < 8; i++) snap[i] = m[i];
    end else begin
      exp = snap[a];
    end
    chk(tag, int'(rdata), exp);
  endtask

  task automatic read_all(string tag);
    do_read(0, tag);
    for (int a = 1; a < 8; a++) do_read(a, tag);
  endtask

  task automatic set_time(int yr, int mo, int dt, int hr, int mi, int se, int hu);
    do_write(6, yr); do_write(5, mo); do_write(4, dt);
    do_write(3, hr); do_write(2, mi); do_write(1, se); do_write(0, hu);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int hv;
    void'($urandom(32'd7170));
    for (int i = 0; i < 8; i++) begin m[i] = lo_of(i); snap[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 rdata after reset", int'(rdata), 0);
    chk("R1 pulses after reset", int'(inc_pulse), 0);
    do_read(4, "R1 hold register reset");
    read_all("R1 R5 reset counters");

    // R2 carries through seconds, minutes, hours
    set_time(30, 7, 15, 10, 59, 59, 99);
    do_tick();
    read_all("R2 R5 carry to hour");
    for (int k = 0; k < 100; k++) do_tick();
    read_all("R2 hundred ticks");

    // R3 day of week wrap with day roll
    do_write(7, 6);
    set_time(30, 7, 15, 23, 59, 59, 99);
    do_tick();
    read_all("R3 day roll");

    // R4 month lengths and year wrap
    set_time(24, 2, 28, 23, 59, 59, 99); do_tick(); read_all("R4 leap February");
    set_time(23, 2, 28, 23, 59, 59, 99); do_tick(); read_all("R4 plain February");
    set_time(30, 4, 30, 23, 59, 59, 99); do_tick(); read_all("R4 thirty-day month");
    set_time(99, 12, 31, 23, 59, 59, 99); do_tick(); read_all("R4 year wrap");
    set_time(30, 6, 31, 23, 59, 59, 99); do_tick(); read_all("R4 oversize day wraps");

    // R6 rdata holds between reads
    do_read(3, "R6 read");
    hv = int'(rdata);
    for (int k = 0; k < 5; k++) do_tick();
    chk("R6 rdata held", int'(rdata), hv);

    // R8 holding registers unaffected by ticks
    do_read(0, "R7 trigger");
    for (int k = 0; k < 250; k++) do_tick();
    for (int a = 1; a < 8; a++) do_read(a, "R8 held after ticks");

    // R9 write wins over a simultaneous tick; write does not touch holds
    do_read(0, "R7 trigger");
    wr_en = 1'b1; tick = 1'b1; addr = 3'd1; wdata = 8'd30;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    m[1] = 30;
    chk("R9 R10 collision pulses", int'(inc_pulse), 0);
    do_read(1, "R9 hold untouched by write");
    read_all("R9 collision tick dropped");

    // Random mix
    for (int k = 0; k < 4000; k++) begin
      int r;
      r = int'($urandom_range(99));
      if (r < 70) do_tick();
      else if (r < 78) do_read(0, "R7 random live read");
      else if (r < 93) do_read(int'($urandom_range(7, 1)), "R8 random held read");
      else begin
        int a;
        a = int'($urandom_range(7));
        do_write(a, lo_of(a) + int'($urandom_range(top_of(a) - lo_of(a))));
      end
    end
    read_all("R2 R4 final state");

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule